// File: doc/BRIEF.md
# NAND Chip-Enable and Strobe Decoder

This block sits between a host card bus and an array of NAND flash devices. It holds two small registers that the host writes: a mode register and a device-select register. From host accesses it derives active-low read and write strobes for the flash. It also drives four active-low chip-enable lines and an active-low 16-bit-access indication back toward the host.

The source of the strobes depends on a space-select bit. When the bit is 0, only an I/O access to the function base address plus 4 produces a strobe. When the bit is 1, every common-memory access produces one.

The chip-enable lines have two encodings, chosen at run time. In one-hot mode exactly one of four lines goes low. In binary mode the lines carry the inverted 4-bit device code, so that external logic can decode up to 15 devices. A code of zero means no device is selected.

Top module: `nand_ce_decoder`

## Requirements
- R1: After reset both registers are zero. All chip enables are high, both strobes are high, and the 16-bit output follows its external pin input.
- R2: A register write takes effect on the next clock edge. Address 0 selects the mode register and address 1 selects the device register. Mode register bit 0 is NAND enable, bit 1 is the encoding mode (1 = binary), bit 2 is the 16-bit indication and bit 3 is the space select. Bits 7..4 are stored as zero.
- R3: With NAND enable at 0, both strobes stay high and all four chip enables stay high, whatever the accesses.
- R4: With space select at 0, the read strobe is low exactly while an I/O read is active at the base plus 4. The write strobe behaves the same way for I/O writes. A memory access or any other I/O address gives no strobe.
- R5: With space select at 1, any active common-memory read lowers the read strobe and any active common-memory write lowers the write strobe. I/O accesses give no strobe.
- R6: Strobes are combinational: they follow the command and address inputs in the same cycle.
- R7: In one-hot mode with NAND enabled, the chip-enable line numbered by device bits 1..0 is low and the other three are high.
- R8: In binary mode with NAND enabled, the chip-enable bus equals the bitwise inverse of device bits 3..0. A code of 0 therefore gives all lines high.
- R9: In NAND mode the 16-bit output is the inverse of mode bit 2. Outside NAND mode it equals the external pin input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mode register, 1 = device register |
| reg_wdata | input | 8 | Register write data |
| base_addr | input | 16 | Function I/O base address |
| host_addr | input | 16 | Host access address |
| io_rd | input | 1 | Host I/O read command active |
| io_wr | input | 1 | Host I/O write command active |
| mem_rd | input | 1 | Host common-memory read active |
| mem_wr | input | 1 | Host common-memory write active |
| ext_wide_n | input | 1 | External 16-bit indication pin, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_we_n | output | 1 | NAND write strobe, active low |
| ce_n | output | 4 | Chip enables, active low |
| wide_n | output | 1 | 16-bit indication to host, active low |

## Verification
The bench sweeps all 16 device codes under both encodings, and under NAND disabled. A design that forgot the inversion in binary mode, or that left one-hot active with the mode bit set, would show the wrong line pattern on one of these codes.

It also sweeps host addresses around base plus 4, using offsets 3, 4 and 5, and checks every command type in both space settings. An off-by-one match, or strobes leaking from the wrong address space, would therefore be caught.

The 16-bit output is checked with the pin at both levels in and out of NAND mode. This catches a design that drives the register bit when it should pass the pin through.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int CE_W      = 4;
    localparam int SEL_W     = $clog2(CE_W);
    localparam int NAND_OFFS = 4;

    typedef struct packed {
        logic space_mem;
        logic wide;
        logic binary;
        logic enable;
    } mode_t;

    typedef enum logic {
        REG_MODE = 1'b0,
        REG_DEV  = 1'b1
    } reg_sel_e;

    function automatic logic [CE_W-1:0] onehot_low(input logic [SEL_W-1:0] sel);
        logic [CE_W-1:0] v;
        v = '1;
        v[sel] = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
    import nand_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode,
    output logic [CE_W-1:0]   dev
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            dev  <= '0;
        end else if (we) begin
            if (reg_sel_e'(addr) == REG_MODE)
                mode <= mode_t'(wdata[3:0]);
            else
                dev <= wdata[CE_W-1:0];
        end
    end
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_dec_pkg::*;
(
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    output logic              re_n,
    output logic              we_n
);
    logic [ADDR_W-1:0] target;
    logic              io_hit;
    logic              rd, wr;

    always_comb begin
        target = base_addr + ADDR_W'(NAND_OFFS);
        io_hit = (host_addr == target);
        if (mode.space_mem) begin
            rd = mem_rd;
            wr = mem_wr;
        end else begin
            rd = io_rd & io_hit;
            wr = io_wr & io_hit;
        end
        re_n = ~(mode.enable & rd);
        we_n = ~(mode.enable & wr);
    end
endmodule

// File: rtl/nand_ce_encode.sv
module nand_ce_encode
    import nand_dec_pkg::*;
(
    input  mode_t           mode,
    input  logic [CE_W-1:0] dev,
    output logic [CE_W-1:0] ce_n
);
    always_comb begin
        if (!mode.enable)
            ce_n = '1;
        else if (mode.binary)
            ce_n = ~dev;
        else
            ce_n = onehot_low(dev[SEL_W-1:0]);
    end
endmodule

// File: rtl/nand_ce_decoder.sv
module nand_ce_decoder
    import nand_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              ext_wide_n,
    output logic              nand_re_n,
    output logic              nand_we_n,
    output logic [CE_W-1:0]   ce_n,
    output logic              wide_n
);
    mode_t           mode;
    logic [CE_W-1:0] dev;

    nand_cfg_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .mode(mode), .dev(dev)
    );

    nand_strobe_gen u_strobe (
        .mode(mode), .base_addr(base_addr), .host_addr(host_addr),
        .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .re_n(nand_re_n), .we_n(nand_we_n)
    );

    nand_ce_encode u_ce (
        .mode(mode), .dev(dev), .ce_n(ce_n)
    );

    assign wide_n = mode.enable ? ~mode.wide : ext_wide_n;
endmodule

// File: rtl/nand_ce_decoder_chk.sv
module nand_ce_decoder_chk
    import nand_dec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            reg_we,
    input logic            io_rd,
    input logic            io_wr,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            nand_re_n,
    input logic            nand_we_n,
    input logic [CE_W-1:0] ce_n
);
    // R3
    ce_idle_after_reset_chk: assert property (@(posedge clk)
        rst |=> (ce_n == '1 && nand_re_n && nand_we_n));
    // R4
    no_read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_rd | mem_rd) |-> nand_re_n);
    // R4
    no_write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr | mem_wr) |-> nand_we_n);
    // R2
    ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(ce_n));
endmodule

bind nand_ce_decoder nand_ce_decoder_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we),
    .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .ce_n(ce_n)
);

// File: tb/nand_ce_decoder_tb.sv
module nand_ce_decoder_tb;
    logic clk = 0, rst = 1;
    logic reg_we = 0, reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [15:0] base_addr = 16'h0300, host_addr = 0;
    logic io_rd = 0, io_wr = 0, mem_rd = 0, mem_wr = 0, ext_wide_n = 1;
    logic nand_re_n, nand_we_n, wide_n;
    logic [3:0] ce_n;
    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    nand_ce_decoder u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic strobe_case(input string req, input logic [15:0] a,
                               input int kind, input logic exp_re, input logic exp_we);
        host_addr = a;
        io_rd = (kind == 0); io_wr = (kind == 1);
        mem_rd = (kind == 2); mem_wr = (kind == 3);
        #1;
        chk(req, {7'b0, nand_re_n}, {7'b0, exp_re});
        chk(req, {7'b0, nand_we_n}, {7'b0, exp_we});
        io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0;
        #1;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                fails++; tests++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {4'b0, ce_n}, 8'h0f);
        chk("R1", {6'b0, nand_re_n, nand_we_n}, 8'h03);
        ext_wide_n = 0; #1; chk("R1", {7'b0, wide_n}, 8'h00);
        ext_wide_n = 1; #1; chk("R1", {7'b0, wide_n}, 8'h01);
        // R3 disabled: sweep devices and accesses
        for (int d = 0; d < 16; d++) begin
            wr_reg(1, 8'(d));
            wr_reg(0, 8'h02);
            chk("R3", {4'b0, ce_n}, 8'h0f);
        end
        for (int k = 0; k < 4; k++) strobe_case("R3", 16'h0304, k, 1, 1);
        // R7 / R8 sweep
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 16; d++) begin
                logic [3:0] e;
                wr_reg(0, m ? 8'h03 : 8'h01);
                wr_reg(1, 8'hf0 | 8'(d));
                e = m ? ~4'(d) : ~(4'b1 << (d % 4));
                chk(m ? "R8" : "R7", {4'b0, ce_n}, {4'b0, e});
            end
        // R2: upper bits stored as zero, write timing
        @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 8'hf1;
        #1; chk("R2", {4'b0, ce_n}, 8'h00); // still binary, dev=f
        @(negedge clk); reg_we = 0;
        chk("R2", {4'b0, ce_n}, 8'h07); // one-hot, sel=3
        // R4 I/O space
        for (int off = 3; off <= 5; off++)
            for (int k = 0; k < 4; k++)
                strobe_case("R4", 16'h0300 + 16'(off), k,
                            !(k == 0 && off == 4), !(k == 1 && off == 4));
        // R6 combinational: same cycle, mid-cycle change
        host_addr = 16'h0304; io_rd = 1; #1;
        chk("R6", {7'b0, nand_re_n}, 8'h00);
        host_addr = 16'h0305; #1;
        chk("R6", {7'b0, nand_re_n}, 8'h01);
        io_rd = 0;
        base_addr = 16'h1000;
        strobe_case("R4", 16'h1004, 1, 1, 0);
        // R5 memory space
        wr_reg(0, 8'h09);
        for (int k = 0; k < 4; k++)
            strobe_case("R5", 16'h7abc, k, k != 2, k != 3);
        // R9
        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 2; p++) begin
                wr_reg(0, w ? 8'h05 : 8'h01);
                ext_wide_n = p[0]; #1;
                chk("R9", {7'b0, wide_n}, {7'b0, ~w[0]});
            end
        wr_reg(0, 8'h04);
        for (int p = 0; p < 2; p++) begin
            ext_wide_n = p[0]; #1;
            chk("R9", {7'b0, wide_n}, {7'b0, p[0]});
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule